// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block caches virtual-to-physical page translations for a processor's memory management unit. Every slot can hold any translation. A lookup compares the requested virtual page number and address-space identifier against all slots in the same cycle. One cycle later the block returns a registered result: hit or miss, the physical frame number, the protection field and the dirty flag. Because each slot is tagged with its address space, a context switch does not require invalidation. A slot marked global answers to any address space.

On a miss, software or an external table walker writes the translation through the refill port. A normal refill places the entry in the lowest-numbered empty slot of the replaceable region. When that region is full, a free-running LFSR picks the victim, and its value is folded into the replaceable index range. The lowest `RSV` slots are reserved. They are written only by explicit, indexed pinned refills and are never chosen as victims. A flush either clears every slot or clears only the non-global slots of one address space.

A store that hits a slot whose dirty flag is clear raises a modify-fault flag. The owner can then record the first write to the page.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is empty, `rsp_valid` is low, and any lookup misses.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_req` high. The result reflects the slot contents as they stood in the request cycle.
- R3: A non-global slot hits only when both the page number and the address-space identifier equal the request.
- R4: A slot written with `fill_global`=1 hits on a page-number match under any address-space identifier.
- R5: On a hit, `rsp_pfn`, `rsp_prot` (2-bit field returned as written) and `rsp_dirty` carry the hitting slot's stored values. On a miss all three are zero. If several slots match, the lowest index wins.
- R6: `rsp_mod_fault` is high only for a lookup with `lk_store`=1 that hits a slot whose dirty flag is 0.
- R7: A non-pinned refill writes the lowest-indexed empty slot at or above index `RSV` when one exists, so no live translation is displaced.
- R8: When all replaceable slots are full, a non-pinned refill evicts exactly one slot at index `RSV` or above. Reserved slots are never evicted.
- R9: A pinned refill (`fill_pin`=1) writes slot `fill_pin_idx`, clamped to `RSV-1`, and replaces whatever that slot held.
- R10: `flush_all` empties every slot, including reserved and global ones.
- R11: `flush_asid_en` empties the non-global slots whose identifier equals `flush_asid`. Global slots and slots of other identifiers are kept.
- R12: A flush and a refill in the same cycle apply the flush only, and the refill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address-space identifier of the request |
| lk_store | input | 1 | The access is a store |
| fill_en | input | 1 | Write a translation |
| fill_pin | input | 1 | Write into a reserved slot by index |
| fill_pin_idx | input | PIN_W | Reserved slot index for pinned writes |
| fill_vpn | input | VPN_W | Page number of the new entry |
| fill_asid | input | ASID_W | Identifier of the new entry |
| fill_pfn | input | PFN_W | Frame number of the new entry |
| fill_prot | input | 2 | Protection field of the new entry |
| fill_dirty | input | 1 | Dirty flag of the new entry |
| fill_global | input | 1 | Entry matches any identifier |
| flush_all | input | 1 | Empty every slot |
| flush_asid_en | input | 1 | Empty non-global slots of one identifier |
| flush_asid | input | ASID_W | Identifier to flush |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pfn | output | PFN_W | Translated frame number |
| rsp_prot | output | 2 | Protection field of the hit |
| rsp_dirty | output | 1 | Dirty flag of the hit |
| rsp_mod_fault | output | 1 | Store to a clean page |

## Verification
A corrupted valid bit, tag or identifier appears at the ports on the first lookup of that page as a spurious hit or miss, one cycle after the request. A bad victim choice shows up as a reserved or still-live translation going missing on the next scan of the stored set. Frame and attribute errors show on the same registered response as a wrong `rsp_pfn`, `rsp_prot`, `rsp_dirty` or fault flag. The bench keeps a slot-indexed shadow of every written translation. While empty slots remain, it can predict placement exactly. After a random eviction it rescans the whole set, so a fault is exposed within one pass.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
// Shared types for the translation cache.
// Assumes a 2-bit protection field throughout the block.
package tlb_pkg;
    localparam int LFSR_W = 16;

    typedef struct packed {
        logic [1:0] prot;
        logic       dirty;
        logic       glob;
    } tlb_attr_t;
endpackage

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
// Parallel tag comparator: flags every live slot whose page number matches and
// whose identifier matches (or is global), then reports the lowest such index.
// Assumes ENTRIES >= 2; purely combinational.
module tlb_match #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0]             glob,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0] asid,
    input  logic [VPN_W-1:0]               req_vpn,
    input  logic [ASID_W-1:0]              req_asid,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx
);
    logic [ENTRIES-1:0] match;

    // one comparator per slot
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = valid[i] && (vpn[i] == req_vpn) &&
                          (glob[i] || (asid[i] == req_asid));
    end

    // lowest matching index wins
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
        hit = |match;
    end
endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
// Refill slot chooser for the replaceable region [RSV, ENTRIES).
// Prefers the lowest empty slot; otherwise folds a free-running LFSR into the
// region. Assumes 1 <= RSV < ENTRIES; the LFSR steps every cycle.
module tlb_victim #(
    parameter int ENTRIES = 32,
    parameter int RSV     = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int SPAN   = ENTRIES - RSV
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    output logic               free_avail,
    output logic [IDX_W-1:0]   victim_idx
);
    import tlb_pkg::*;

    logic [LFSR_W-1:0] lfsr_q;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  rand_idx;

    // maximal-length 16-bit Fibonacci LFSR, seeded non-zero at reset
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= 16'hACE1;
        else        lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end

    // lowest empty slot in the replaceable region
    always_comb begin
        free_avail = 1'b0;
        free_idx   = IDX_W'(RSV);
        for (int i = ENTRIES - 1; i >= RSV; i--) begin
            if (!valid[i]) begin
                free_avail = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    // fold the random value into the replaceable range
    assign rand_idx   = IDX_W'(RSV) + IDX_W'(lfsr_q % LFSR_W'(SPAN));
    assign victim_idx = free_avail ? free_idx : rand_idx;
endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
// Fully associative, identifier-tagged translation cache.
// Holds the slot storage, applies refills and flushes, and registers the
// lookup result one cycle after the request. Assumes software never writes
// two live slots that match the same request.
module xlat_cache #(
    parameter int ENTRIES = 32,
    parameter int RSV     = 4,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PIN_W  = (RSV > 1) ? $clog2(RSV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_store,
    input  logic              fill_en,
    input  logic              fill_pin,
    input  logic [PIN_W-1:0]  fill_pin_idx,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [1:0]        fill_prot,
    input  logic              fill_dirty,
    input  logic              fill_global,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [1:0]        rsp_prot,
    output logic              rsp_dirty,
    output logic              rsp_mod_fault
);
    import tlb_pkg::*;

    logic      [ENTRIES-1:0]             v_q;
    logic      [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
    logic      [ENTRIES-1:0][ASID_W-1:0] asid_q;
    logic      [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
    tlb_attr_t [ENTRIES-1:0]             attr_q;
    logic      [ENTRIES-1:0]             glob_v;

    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic             free_avail;
    logic [IDX_W-1:0] victim_idx;
    logic [IDX_W-1:0] wr_idx;
    logic             flush_any;

    // gather global flags for the comparator
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) glob_v[i] = attr_q[i].glob;
    end

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
        .valid(v_q), .glob(glob_v), .vpn(vpn_q), .asid(asid_q),
        .req_vpn(lk_vpn), .req_asid(lk_asid), .hit(hit), .hit_idx(hit_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES), .RSV(RSV)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid(v_q),
        .free_avail(free_avail), .victim_idx(victim_idx)
    );

    // pick the write slot: clamped reserved index, or the chooser's pick
    always_comb begin
        if (!fill_pin)                    wr_idx = victim_idx;
        else if (32'(fill_pin_idx) < RSV) wr_idx = IDX_W'(fill_pin_idx);
        else                              wr_idx = IDX_W'(RSV - 1);
    end

    assign flush_any = flush_all || flush_asid_en;

    // valid bits: reset, flushes (priority), then refill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
        end else if (flush_all) begin
            v_q <= '0;
        end else if (flush_asid_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!attr_q[i].glob && asid_q[i] == flush_asid) v_q[i] <= 1'b0;
            end
        end else if (fill_en) begin
            v_q[wr_idx] <= 1'b1;
        end
    end

    // slot payload written on an accepted refill
    always_ff @(posedge clk) begin
        if (fill_en && !flush_any) begin
            vpn_q[wr_idx]  <= fill_vpn;
            asid_q[wr_idx] <= fill_asid;
            pfn_q[wr_idx]  <= fill_pfn;
            attr_q[wr_idx] <= '{prot: fill_prot, dirty: fill_dirty, glob: fill_global};
        end
    end

    // registered lookup response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_pfn       <= '0;
            rsp_prot      <= '0;
            rsp_dirty     <= 1'b0;
            rsp_mod_fault <= 1'b0;
        end else begin
            rsp_valid     <= lk_req;
            rsp_hit       <= lk_req && hit;
            rsp_pfn       <= (lk_req && hit) ? pfn_q[hit_idx] : '0;
            rsp_prot      <= (lk_req && hit) ? attr_q[hit_idx].prot : 2'b00;
            rsp_dirty     <= lk_req && hit && attr_q[hit_idx].dirty;
            rsp_mod_fault <= lk_req && hit && lk_store && !attr_q[hit_idx].dirty;
        end
    end

    // R2: response follows the request by one cycle
    a_r2_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);
    // R5: a miss returns zeroed payload
    a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_pfn == '0 && rsp_prot == 2'b00 && !rsp_dirty));
    // R6: a fault only accompanies a clean hit
    a_r6_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_mod_fault |-> (rsp_hit && !rsp_dirty));
    // R7: filling an empty slot adds exactly one live entry
    a_r7_fill_free: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !fill_pin && !flush_any && free_avail) |=>
            ($countones(v_q) == $past($countones(v_q)) + 1));
    // R8: a non-pinned refill leaves reserved slots untouched
    a_r8_rsv_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !fill_pin && !flush_any) |=>
            ($stable(v_q[RSV-1:0]) && $stable(pfn_q[RSV-1:0])));
    // R10: a full flush empties everything
    a_r10_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (v_q == '0));
endmodule

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
    localparam int N = 32;
    localparam int RSV = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic lk_req = 0, lk_store = 0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic fill_en = 0, fill_pin = 0, fill_dirty = 0, fill_global = 0;
    logic [1:0]  fill_pin_idx = '0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic [7:0]  fill_asid = '0;
    logic [1:0]  fill_prot = '0;
    logic flush_all = 0, flush_asid_en = 0;
    logic [7:0]  flush_asid = '0;
    logic rsp_valid, rsp_hit, rsp_dirty, rsp_mod_fault;
    logic [19:0] rsp_pfn;
    logic [1:0]  rsp_prot;

    int nchk = 0, nfail = 0;
    bit done = 0;

    // shadow model, slot-indexed
    bit        m_v[N];
    bit [19:0] m_vpn[N];
    bit [7:0]  m_asid[N];
    bit        m_g[N];
    bit [19:0] m_pfn[N];
    bit [1:0]  m_prot[N];
    bit        m_d[N];

    xlat_cache u_xlat_cache (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_store(lk_store), .fill_en(fill_en), .fill_pin(fill_pin),
        .fill_pin_idx(fill_pin_idx), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_prot(fill_prot), .fill_dirty(fill_dirty),
        .fill_global(fill_global), .flush_all(flush_all), .flush_asid_en(flush_asid_en),
        .flush_asid(flush_asid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_pfn(rsp_pfn), .rsp_prot(rsp_prot), .rsp_dirty(rsp_dirty),
        .rsp_mod_fault(rsp_mod_fault)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected {hit,pfn,prot,dirty,fault} from the shadow, lowest slot first
    function automatic logic [24:0] expect_lookup(input bit [19:0] vpn, input bit [7:0] asid, input bit st);
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asid[i] == asid))
                return {1'b1, m_pfn[i], m_prot[i], m_d[i], st & ~m_d[i]};
        end
        return '0;
    endfunction

    task automatic lookup(input bit [19:0] vpn, input bit [7:0] asid, input bit st, output logic [24:0] res);
        lk_req = 1; lk_vpn = vpn; lk_asid = asid; lk_store = st;
        @(posedge clk); @(negedge clk);
        lk_req = 0; lk_store = 0;
        check(rsp_valid === 1'b1, "R2 valid after request", 32'(rsp_valid), 32'd1);
        res = {rsp_hit, rsp_pfn, rsp_prot, rsp_dirty, rsp_mod_fault};
    endtask

    task automatic look_chk(input bit [19:0] vpn, input bit [7:0] asid, input bit st, input string req);
        logic [24:0] r, e;
        e = expect_lookup(vpn, asid, st);
        lookup(vpn, asid, st, r);
        check(r === e, req, 32'(r), 32'(e));
    endtask

    task automatic fill(input bit pin, input bit [1:0] pidx, input bit [19:0] vpn, input bit [7:0] asid,
                        input bit [19:0] pfn, input bit [1:0] prot, input bit d, input bit g);
        fill_en = 1; fill_pin = pin; fill_pin_idx = pidx; fill_vpn = vpn; fill_asid = asid;
        fill_pfn = pfn; fill_prot = prot; fill_dirty = d; fill_global = g;
        @(posedge clk); @(negedge clk);
        fill_en = 0; fill_pin = 0;
    endtask

    task automatic model_put(input int i, input bit [19:0] vpn, input bit [7:0] asid,
                             input bit [19:0] pfn, input bit [1:0] prot, input bit d, input bit g);
        m_v[i] = 1; m_vpn[i] = vpn; m_asid[i] = asid; m_pfn[i] = pfn;
        m_prot[i] = prot; m_d[i] = d; m_g[i] = g;
    endtask

    task automatic scan_all(input string req);
        for (int i = 0; i < N; i++)
            if (m_v[i]) look_chk(m_vpn[i], m_asid[i], 1'b0, req);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [24:0] r;
        void'($urandom(32'h5EED));
        for (int i = 0; i < N; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: quiet and empty after reset
        check(rsp_valid === 1'b0, "R1 rsp_valid low", 32'(rsp_valid), 0);
        look_chk(20'h00005, 8'h00, 1'b0, "R1 empty miss");
        @(negedge clk);
        check(rsp_valid === 1'b0, "R2 no request no valid", 32'(rsp_valid), 0);

        // R9/R5: pinned slot 0, then R3 identifier mismatch, R6 dirty store
        fill(1, 2'd0, 20'h00ABC, 8'd7, 20'h00111, 2'b11, 1'b1, 1'b0);
        model_put(0, 20'h00ABC, 8'd7, 20'h00111, 2'b11, 1'b1, 1'b0);
        look_chk(20'h00ABC, 8'd7, 1'b1, "R5 R9 pinned hit, R6 dirty store no fault");
        look_chk(20'h00ABC, 8'd8, 1'b0, "R3 asid mismatch misses");

        // R7: fill the replaceable region; placement is lowest empty slot
        for (int k = 0; k < N - RSV; k++) begin
            bit [19:0] v, p; bit [7:0] a; bit g, d; bit [1:0] pr;
            v = {12'($urandom), 8'(k)}; p = 20'($urandom); a = 8'(1 + $urandom % 3);
            g = ($urandom % 8) == 0; d = $urandom % 2; pr = 2'($urandom);
            fill(0, 2'd0, v, a, p, pr, d, g);
            model_put(RSV + k, v, a, p, pr, d, g);
        end
        scan_all("R7 no displacement while empty slots remain");

        // R3/R4/R5/R6: random lookups against the shadow
        for (int n = 0; n < 200; n++) begin
            int k; bit [7:0] a; bit [19:0] v;
            k = RSV + ($urandom % (N - RSV));
            case ($urandom % 3)
                0: begin v = m_vpn[k]; a = m_asid[k]; end
                1: begin v = m_vpn[k]; a = 8'($urandom % 4); end
                default: begin v = {12'($urandom), 8'hF0}; a = 8'($urandom % 4); end
            endcase
            look_chk(v, a, $urandom % 2, "R3 R4 R5 R6 random lookup");
        end

        // R8: refills when full evict exactly one replaceable slot
        for (int e = 0; e < 3; e++) begin
            bit [19:0] v; int lost, lost_idx;
            v = {12'h3C0 + 12'(e), 8'h80};
            fill(0, 2'd0, v, 8'd1, 20'h0BEEF + 20'(e), 2'b01, 1'b0, 1'b0);
            lost = 0; lost_idx = 0;
            for (int i = RSV; i < N; i++) begin
                lookup(m_vpn[i], m_asid[i], 1'b0, r);
                if (!r[24]) begin lost++; lost_idx = i; end
            end
            check(lost == 1, "R8 exactly one eviction", 32'(lost), 32'd1);
            look_chk(20'h00ABC, 8'd7, 1'b0, "R8 reserved slot survives");
            m_v[lost_idx] = 0;
            model_put(lost_idx, v, 8'd1, 20'h0BEEF + 20'(e), 2'b01, 1'b0, 1'b0);
            look_chk(v, 8'd1, 1'b1, "R8 new entry hits, R6 clean store faults");
        end

        // R12: flush wins over a same-cycle refill; R11 identifier flush
        flush_asid_en = 1; flush_asid = 8'd2;
        fill(1, 2'd1, 20'h00900, 8'd9, 20'h00999, 2'b10, 1'b1, 1'b0);
        flush_asid_en = 0;
        for (int i = 0; i < N; i++)
            if (m_v[i] && !m_g[i] && m_asid[i] == 8'd2) m_v[i] = 0;
        look_chk(20'h00900, 8'd9, 1'b0, "R12 refill dropped under flush");
        for (int i = 0; i < N; i++) begin
            if (m_v[i]) look_chk(m_vpn[i], m_asid[i], 1'b0, "R11 survivors hit");
        end
        for (int k = RSV; k < N; k++) begin
            if (!m_v[k]) begin
                lookup(m_vpn[k], 8'd2, 1'b0, r);
                check(r[24] == 1'b0, "R11 flushed asid misses", 32'(r[24]), 0);
            end
        end
        // R4: a global slot answers every identifier
        fill(1, 2'd3, 20'h00777, 8'd5, 20'h00C0D, 2'b01, 1'b1, 1'b1);
        model_put(3, 20'h00777, 8'd5, 20'h00C0D, 2'b01, 1'b1, 1'b1);
        look_chk(20'h00777, 8'd200, 1'b0, "R4 global hit other asid");

        // R9: pinned overwrite replaces slot 0
        fill(1, 2'd0, 20'h00DEF, 8'd7, 20'h00222, 2'b10, 1'b0, 1'b0);
        model_put(0, 20'h00DEF, 8'd7, 20'h00222, 2'b10, 1'b0, 1'b0);
        look_chk(20'h00ABC, 8'd7, 1'b0, "R9 old pinned entry gone");
        look_chk(20'h00DEF, 8'd7, 1'b1, "R9 new pinned entry, R6 fault");

        // R10: flush everything, including global and reserved
        flush_all = 1; @(posedge clk); @(negedge clk); flush_all = 0;
        for (int i = 0; i < N; i++) begin
            if (m_v[i]) begin
                lookup(m_vpn[i], m_asid[i], 1'b0, r);
                check(r === '0, "R10 flushed slot misses", 32'(r), 0);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule